// File: doc/BRIEF.md
# Address-Generation Hazard Stall Unit

This block sits between decode and operand address generation in an in-order pipeline. Each cycle it looks at the descriptor of the instruction waiting to issue. It compares the registers that instruction reads for its address (a base register and an optionally scaled index register) against the destination of the instruction that issued just before it. From that comparison it works out how many cycles the waiting instruction must be held.

The upstream stage presents a descriptor with `in_valid`. The unit returns `in_ready`. When a dependency is found, `in_ready` stays low for exactly the computed number of cycles, and the upstream stage keeps its descriptor unchanged during that time. An internal down-counter times the hold. Once the hold has run, the earlier result counts as available, and the descriptor is accepted on the next ready cycle.

The stall length depends on how the dependent register is read:
- A base read or a ×1 index read costs a short stall.
- A scaled index read costs a longer one.
- Reading a data register written by a multiply costs the multiply latency.
- Producers marked as forwarding (immediate loads, effective-address loads, clears, and memory forms whose results are bypassed) never cause a hold. Pointer updates from post-increment and pre-decrement addressing are bypassed too, so they are never recorded as producers.

Top module: `agen_hazard_stall`

## Requirements
- R1: After reset, with no instruction yet issued, `in_ready` is 1 and `stall_len` is 0.
- R2: Suppose the previous issued instruction wrote register X without the forward flag or the multiply flag. A waiting instruction that reads X as base is held for `BASE_STALL` (default 2) cycles.
- R3: In the same case, reading X as index with scale code 0 (×1) holds for `BASE_STALL` (2) cycles.
- R4: In the same case, reading X as index with scale codes 1, 2 or 3 (×2, ×4, ×8) holds for `SCALED_STALL` (3) cycles.
- R5: A producer with the multiply flag and a data-file destination (code bit 3 = 0) holds any base or index reader of that register for `MUL_STALL` (3) cycles. With an address-file destination, the R2 to R4 rules apply instead.
- R6: A producer with the forward flag set never causes a hold (stall 0).
- R7: When base and index both match, the hold is the larger of the two counts.
- R8: A register code is 4 bits: bit 3 = 1 selects the address file and bits 2:0 give the number. A match needs all 4 bits equal, so D2 (code 2) and A2 (code 10) never match.
- R9: For a computed stall N > 0, `in_ready` is low for exactly N consecutive cycles while `in_valid` is held, and is then high. `stall_len` shows N in the first cycle the descriptor is presented.
- R10: Only the immediately preceding issued instruction is compared. A producer with `dst_vld` = 0, or one followed by an unrelated instruction, causes no hold.
- R11: A synchronous reset during a hold clears the counter and the recorded producer, so `in_ready` is 1 and `stall_len` is 0 on the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A descriptor is presented |
| in_ready | output | 1 | Descriptor accepted this cycle when `in_valid` is also high |
| dst_vld | input | 1 | Instruction writes a register |
| dst_reg | input | REG_W | Destination register code |
| dst_fwd | input | 1 | Destination result is forwarded (never stalls) |
| dst_mul | input | 1 | Destination is a multiply result |
| base_vld | input | 1 | Address uses a base register |
| base_reg | input | REG_W | Base register code |
| idx_vld | input | 1 | Address uses an index register |
| idx_reg | input | REG_W | Index register code |
| idx_scale | input | 2 | Index scale code: 0 ×1, 1 ×2, 2 ×4, 3 ×8 |
| stall_len | output | CNT_W | Hold length computed for the presented descriptor |

## Verification
The assertions assume that the upstream stage keeps `in_valid` high and its descriptor unchanged while `in_ready` is low. They also assume that the flags of a descriptor are meaningful only when `in_valid` is high. The stimulus keeps to this: a driver task sets a full descriptor and holds it until it sees acceptance. It drops `in_valid` only between instructions or while reset is asserted. Each producer and consumer pair is sent back to back, so the consumer is compared only against its intended producer, with filler instructions inserted only where R10 calls for them.

// File: rtl/agh_pkg.sv
package agh_pkg;

   typedef enum logic [1:0] {
      SC_X1 = 2'd0,
      SC_X2 = 2'd1,
      SC_X4 = 2'd2,
      SC_X8 = 2'd3
   } agh_scale_e;

   function automatic int agh_max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/agh_match.sv
module agh_match #(
   parameter int REG_W = 4
) (
   input  logic             prod_vld,
   input  logic [REG_W-1:0] prod_reg,
   input  logic             use_vld,
   input  logic [REG_W-1:0] use_reg,
   output logic             hit
);

   if (REG_W < 2) begin : g_bad_width
      $error("agh_match: REG_W must be at least 2");
   end

   logic [REG_W-1:0] bit_eq;

   for (genvar i = 0; i < REG_W; i++) begin : g_bit
      assign bit_eq[i] = ~(prod_reg[i] ^ use_reg[i]);
   end

   assign hit = prod_vld && use_vld && (&bit_eq);

endmodule

// File: rtl/agh_cost.sv
module agh_cost
   import agh_pkg::*;
#(
   parameter int REG_W        = 4,
   parameter int CNT_W        = 2,
   parameter int BASE_STALL   = 2,
   parameter int SCALED_STALL = 3,
   parameter int MUL_STALL    = 3
) (
   input  logic             prod_vld,
   input  logic [REG_W-1:0] prod_reg,
   input  logic             prod_mul,
   input  logic             base_vld,
   input  logic [REG_W-1:0] base_reg,
   input  logic             idx_vld,
   input  logic [REG_W-1:0] idx_reg,
   input  logic [1:0]       idx_scale,
   output logic [CNT_W-1:0] stall
);

   localparam logic [CNT_W-1:0] L_BASE   = CNT_W'(BASE_STALL);
   localparam logic [CNT_W-1:0] L_SCALED = CNT_W'(SCALED_STALL);
   localparam logic [CNT_W-1:0] L_MUL    = CNT_W'(MUL_STALL);

   if (agh_max3(BASE_STALL, SCALED_STALL, MUL_STALL) >= (1 << CNT_W)) begin : g_bad_cnt
      $error("agh_cost: CNT_W too narrow for stall lengths");
   end

   logic       base_hit;
   logic       idx_hit;
   logic       mul_data;
   agh_scale_e scale;
   logic [CNT_W-1:0] c_base, c_idx, c_mul, c_bi;

   agh_match #(.REG_W(REG_W)) u_base_cmp (
      .prod_vld (prod_vld),
      .prod_reg (prod_reg),
      .use_vld  (base_vld),
      .use_reg  (base_reg),
      .hit      (base_hit)
   );

   agh_match #(.REG_W(REG_W)) u_idx_cmp (
      .prod_vld (prod_vld),
      .prod_reg (prod_reg),
      .use_vld  (idx_vld),
      .use_reg  (idx_reg),
      .hit      (idx_hit)
   );

   // bit REG_W-1 = 0 marks the data file
   assign mul_data = prod_mul && !prod_reg[REG_W-1];
   assign scale    = agh_scale_e'(idx_scale);

   always_comb begin
      c_base = base_hit ? L_BASE : '0;
      c_idx  = '0;
      if (idx_hit) begin
         c_idx = (scale == SC_X1) ? L_BASE : L_SCALED;
      end
      c_mul  = (mul_data && (base_hit || idx_hit)) ? L_MUL : '0;
      c_bi   = (c_base > c_idx) ? c_base : c_idx;
      stall  = (c_bi > c_mul) ? c_bi : c_mul;
   end

endmodule

// File: rtl/agh_downcnt.sv
module agh_downcnt #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             zero
);

   if (CNT_W < 1) begin : g_bad_w
      $error("agh_downcnt: CNT_W must be positive");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign zero = (cnt == '0);

   // R9: a running hold counts down by one each cycle
   assert_count_down_R9: assert property (@(posedge clk) disable iff (rst)
      (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   // R11: reset leaves the counter empty
   assert_reset_clears_R11: assert property (@(posedge clk)
      rst |=> zero);

endmodule

// File: rtl/agen_hazard_stall.sv
module agen_hazard_stall #(
   parameter int REG_W        = 4,
   parameter int BASE_STALL   = 2,
   parameter int SCALED_STALL = 3,
   parameter int MUL_STALL    = 3,
   localparam int MAX_STALL   = agh_pkg::agh_max3(BASE_STALL, SCALED_STALL, MUL_STALL),
   localparam int CNT_W       = $clog2(MAX_STALL + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic             dst_vld,
   input  logic [REG_W-1:0] dst_reg,
   input  logic             dst_fwd,
   input  logic             dst_mul,
   input  logic             base_vld,
   input  logic [REG_W-1:0] base_reg,
   input  logic             idx_vld,
   input  logic [REG_W-1:0] idx_reg,
   input  logic [1:0]       idx_scale,
   output logic [CNT_W-1:0] stall_len
);

   if (BASE_STALL < 1 || SCALED_STALL < 1 || MUL_STALL < 1) begin : g_bad_stall
      $error("agen_hazard_stall: stall lengths must be at least 1");
   end

   logic             prod_vld;
   logic [REG_W-1:0] prod_reg;
   logic             prod_mul;
   logic [CNT_W-1:0] need;
   logic [CNT_W-1:0] cnt;
   logic             zero;
   logic             load;
   logic             go;

   agh_cost #(
      .REG_W        (REG_W),
      .CNT_W        (CNT_W),
      .BASE_STALL   (BASE_STALL),
      .SCALED_STALL (SCALED_STALL),
      .MUL_STALL    (MUL_STALL)
   ) u_cost (
      .prod_vld  (prod_vld),
      .prod_reg  (prod_reg),
      .prod_mul  (prod_mul),
      .base_vld  (base_vld),
      .base_reg  (base_reg),
      .idx_vld   (idx_vld),
      .idx_reg   (idx_reg),
      .idx_scale (idx_scale),
      .stall     (need)
   );

   assign load = in_valid && zero && (need != '0);

   agh_downcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .load_val (need - 1'b1),
      .cnt      (cnt),
      .zero     (zero)
   );

   assign in_ready  = zero && (need == '0);
   assign go        = in_valid && in_ready;
   assign stall_len = need;

   // record the last issued producer; a started hold retires it
   always_ff @(posedge clk) begin
      if (rst) begin
         prod_vld <= 1'b0;
         prod_reg <= '0;
         prod_mul <= 1'b0;
      end else if (go) begin
         prod_vld <= dst_vld && !dst_fwd;
         prod_reg <= dst_reg;
         prod_mul <= dst_mul;
      end else if (load) begin
         prod_vld <= 1'b0;
      end
   end

   // R9: upstream keeps a stalled descriptor in place
   assert_hold_input_R9: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_ready) |=> (in_valid && $stable(base_reg) && $stable(idx_reg)));

   // R9: counter length follows the cost computed on arrival
   assert_load_len_R9: assert property (@(posedge clk) disable iff (rst)
      load |=> (cnt == $past(need) - 1'b1));

   // R6: a forwarded producer never holds the next instruction
   assert_fwd_free_R6: assert property (@(posedge clk) disable iff (rst)
      (go && dst_fwd) |=> (stall_len == '0));

   // R10: a producer without a destination never holds the next instruction
   assert_no_dst_free_R10: assert property (@(posedge clk) disable iff (rst)
      (go && !dst_vld) |=> (stall_len == '0));

endmodule

// File: tb/tb_agen_hazard_stall.sv
`timescale 1ns/1ps
module tb_agen_hazard_stall;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic       dst_vld = 1'b0;
   logic [3:0] dst_reg = '0;
   logic       dst_fwd = 1'b0;
   logic       dst_mul = 1'b0;
   logic       base_vld = 1'b0;
   logic [3:0] base_reg = '0;
   logic       idx_vld = 1'b0;
   logic [3:0] idx_reg = '0;
   logic [1:0] idx_scale = '0;
   logic [1:0] stall_len;

   int n_chk = 0;
   int n_bad = 0;
   int exp_q[$];
   string tag_q[$];
   int wait_cnt = 0;
   int first_sl = 0;

   always #2.5 clk = ~clk;

   agen_hazard_stall dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .dst_vld(dst_vld), .dst_reg(dst_reg), .dst_fwd(dst_fwd), .dst_mul(dst_mul),
      .base_vld(base_vld), .base_reg(base_reg), .idx_vld(idx_vld),
      .idx_reg(idx_reg), .idx_scale(idx_scale), .stall_len(stall_len)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // driver: present one descriptor, queue the expected hold, wait for acceptance
   task automatic issue(input string tag,
                        input logic dv, input logic [3:0] dr, input logic fw, input logic mu,
                        input logic bv, input logic [3:0] br,
                        input logic iv, input logic [3:0] ir, input logic [1:0] sc,
                        input int exp);
      logic acc;
      @(posedge clk); #1;
      dst_vld = dv; dst_reg = dr; dst_fwd = fw; dst_mul = mu;
      base_vld = bv; base_reg = br; idx_vld = iv; idx_reg = ir; idx_scale = sc;
      in_valid = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      do begin
         @(negedge clk);
         acc = in_ready;
         @(posedge clk);
      end while (!acc);
      #1 in_valid = 1'b0;
   endtask

   // monitor: count ready-low cycles per instruction and compare on acceptance
   always @(negedge clk) begin
      if (rst) begin
         wait_cnt = 0;
      end else if (in_valid) begin
         if (wait_cnt == 0 && !in_ready) first_sl = int'(stall_len);
         if (!in_ready) begin
            wait_cnt++;
         end else if (exp_q.size() > 0) begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " hold cycles"}, wait_cnt, e);
            if (wait_cnt == 0) check({t, " stall_len"}, int'(stall_len), e);
            else check({t, " stall_len R9"}, first_sl, e);
            wait_cnt = 0;
         end
      end
   end

   initial begin
      #(200000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      check("R1 ready after reset", int'(in_ready), 1);
      check("R1 stall_len after reset", int'(stall_len), 0);

      // codes: Dn = n, An = 8+n
      issue("R2 prod D1",     1, 4'd1, 0, 0, 0, 4'd0, 0, 4'd0, 2'd0, 0);
      issue("R2 base D1",     0, 4'd0, 0, 0, 1, 4'd1, 0, 4'd0, 2'd0, 2);
      issue("R3 prod A2",     1, 4'd10, 0, 0, 0, 4'd0, 0, 4'd0, 2'd0, 0);
      issue("R3 idx A2 x1",   0, 4'd0, 0, 0, 0, 4'd0, 1, 4'd10, 2'd0, 2);
      issue("R4 prod D3",     1, 4'd3, 0, 0, 0, 4'd0, 0, 4'd0, 2'd0, 0);
      issue("R4 idx D3 x2",   0, 4'd0, 0, 0, 0, 4'd0, 1, 4'd3, 2'd1, 3);
      issue("R4 prod D4",     1, 4'd4, 0, 0, 0, 4'd0, 0, 4'd0, 2'd0, 0);
      issue("R4 idx D4 x4",   0, 4'd0, 0, 0, 0, 4'd0, 1, 4'd4, 2'd2, 3);
      issue("R5 mul D5",      1, 4'd5, 0, 1, 0, 4'd0, 0, 4'd0, 2'd0, 0);
      issue("R5 base D5",     0, 4'd0, 0, 0, 1, 4'd5, 0, 4'd0, 2'd0, 3);
      issue("R5 mul D6",      1, 4'd6, 0, 1, 0, 4'd0, 0, 4'd0, 2'd0, 0);
      issue("R5 idx D6 x1",   0, 4'd0, 0, 0, 0, 4'd0, 1, 4'd6, 2'd0, 3);
      issue("R5 mul A3",      1, 4'd11, 0, 1, 0, 4'd0, 0, 4'd0, 2'd0, 0);
      issue("R5 base A3",     0, 4'd0, 0, 0, 1, 4'd11, 0, 4'd0, 2'd0, 2);
      issue("R6 fwd A4",      1, 4'd12, 1, 0, 0, 4'd0, 0, 4'd0, 2'd0, 0);
      issue("R6 base A4",     0, 4'd0, 0, 0, 1, 4'd12, 1, 4'd12, 2'd2, 0);
      issue("R8 prod D2",     1, 4'd2, 0, 0, 0, 4'd0, 0, 4'd0, 2'd0, 0);
      issue("R8 base A2",     0, 4'd0, 0, 0, 1, 4'd10, 0, 4'd0, 2'd0, 0);
      issue("R7 prod A5",     1, 4'd13, 0, 0, 0, 4'd0, 0, 4'd0, 2'd0, 0);
      issue("R7 base+idx A5", 0, 4'd0, 0, 0, 1, 4'd13, 1, 4'd13, 2'd2, 3);
      issue("R10 prod D7",    1, 4'd7, 0, 0, 0, 4'd0, 0, 4'd0, 2'd0, 0);
      issue("R10 filler",     0, 4'd0, 0, 0, 0, 4'd0, 0, 4'd0, 2'd0, 0);
      issue("R10 base D7",    0, 4'd0, 0, 0, 1, 4'd7, 0, 4'd0, 2'd0, 0);
      issue("R10 no-dst D0",  0, 4'd0, 0, 0, 0, 4'd0, 0, 4'd0, 2'd0, 0);
      issue("R10 base D0",    0, 4'd0, 0, 0, 1, 4'd0, 0, 4'd0, 2'd0, 0);
      issue("R4 prod A6",     1, 4'd14, 0, 0, 0, 4'd0, 0, 4'd0, 2'd0, 0);
      issue("R4 idx A6 x8",   0, 4'd0, 0, 0, 0, 4'd0, 1, 4'd14, 2'd3, 3);

      // R11: reset in the middle of a hold
      issue("R11 prod A1",    1, 4'd9, 0, 0, 0, 4'd0, 0, 4'd0, 2'd0, 0);
      @(posedge clk); #1;
      dst_vld = 0; base_vld = 1; base_reg = 4'd9; idx_vld = 0;
      in_valid = 1'b1;
      @(negedge clk);
      check("R11 hold started", int'(in_ready), 0);
      @(posedge clk); #1;
      rst = 1'b1; in_valid = 1'b0;
      @(posedge clk); #1;
      rst = 1'b0;
      @(negedge clk);
      check("R11 ready after reset", int'(in_ready), 1);
      check("R11 stall_len after reset", int'(stall_len), 0);
      issue("R11 base A1",    0, 4'd0, 0, 0, 1, 4'd9, 0, 4'd0, 2'd0, 0);

      repeat (3) @(posedge clk);
      check("R9 queue drained", exp_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule